// File: doc/BRIEF.md
# Nanosecond Alarm Timer

This peripheral keeps a free-running 64-bit time count in nanoseconds and compares it against one programmable alarm. The count starts at zero out of reset and grows by a fixed, parameterised number of nanoseconds on every clock. Software sees the count through a 32-bit register window of 4 KiB. Reading the low word of the time also copies the whole count into a holding register, and the next read of the high word returns the upper half of that copy. The two halves therefore always belong to the same instant, even when a carry crosses bit 32 between the two reads.

The alarm is a signed 64-bit value. Software loads it in two writes: the upper word first, then the lower word. Only the lower-word write acts. It compares the assembled value with the current time. If the alarm is not later than the time, the interrupt goes high at once. Otherwise the one-shot comparator is armed, and it raises the interrupt on the first clock at which the time has reached the alarm. The interrupt is a level output. Software drops it with an acknowledge write, or with a cancel write that also disarms any pending alarm.

Every request gets a response on the next clock. An access the block does not define returns zero together with an error flag and leaves all state as it was.

Top module: `nsec_alarm_timer`

## Requirements
- R1: After reset the time is zero, and it grows by INC_NS on every clock. A read of offset 0x00 returns bits 31:0 of the time held in the cycle the request is accepted.
- R2: A read of offset 0x04 returns bits 63:32 of the time captured by the most recent read of 0x00, not of the live count. The value is zero if no such read has happened since reset.
- R3: A write of offset 0x0C only stores alarm bits 63:32. It does not arm the alarm, fire it, or change the interrupt.
- R4: A write of offset 0x08 stores alarm bits 31:0. If the combined alarm is less than or equal to the current time, the interrupt is high on the next cycle and the alarm is left unarmed.
- R5: If that write finds the alarm later than the time, the alarm is armed. The interrupt then rises after the first clock at which the pre-edge time is at least the alarm, and that clock disarms the alarm.
- R6: A write of offset 0x10 drives the interrupt low on the next cycle and leaves the armed state unchanged.
- R7: A write of offset 0x14 disarms the alarm and drives the interrupt low on the next cycle.
- R8: The alarm-versus-time comparison is signed. An alarm whose bit 63 is set lies in the past.
- R9: Any other access is an error: another offset, an offset that is not word aligned, a read of 0x08/0x0C/0x10/0x14, or a write of 0x00/0x04. An error returns data 0 with the error flag set and changes no state.
- R10: Each accepted request produces exactly one response cycle, on the cycle after acceptance. No response appears without a request.
- R11: The interrupt is low out of reset. Once high, it stays high until a 0x10 or 0x14 write.
- R12: A clock that carries any bus write does not fire an armed alarm. The fire is deferred to the first clock without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access was not defined |
| irq | output | 1 | Level interrupt |

## Verification
The bench counts rising edges since reset. It drives each request on a falling edge and samples the outputs on the next falling edge. Read data and the error flag are checked one cycle after the request. A time read is expected to equal INC_NS times the edge count at the moment the request was driven. An immediate alarm must show its interrupt one cycle after the low-word write. An armed alarm must first show its interrupt at edge count ceil(alarm/INC_NS)+1; the bench works this out arithmetically and compares it with the edge count at which the interrupt is first seen high. A sweep covers alarms a few increments before, on and after the current time, with offsets of -1, 0 and +1 ns, so that the equal-time boundary and the one-cycle write deferral are each checked at an exact cycle.

// File: rtl/nsec_alarm_timer.sv
module nsec_alarm_timer #(
  parameter logic [63:0] INC_NS = 64'd1,
  parameter int          ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFF_TLO  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFF_THI  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFF_ALO  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFF_AHI  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFF_ACK  = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFF_CANC = ADDR_W'(12'h014);

  logic [63:0] time_q;
  logic [31:0] snap_hi_q;
  logic [31:0] alarm_lo_q;
  logic [31:0] alarm_hi_q;
  logic        armed_q;
  logic        irq_q;
  logic        rsp_valid_q;
  logic        rsp_err_q;
  logic [31:0] rsp_rdata_q;

  wire hit_tlo  = req_addr == OFF_TLO;
  wire hit_thi  = req_addr == OFF_THI;
  wire hit_alo  = req_addr == OFF_ALO;
  wire hit_ahi  = req_addr == OFF_AHI;
  wire hit_ack  = req_addr == OFF_ACK;
  wire hit_canc = req_addr == OFF_CANC;

  wire rd_ok   = !req_write && (hit_tlo || hit_thi);
  wire wr_ok   = req_write && (hit_alo || hit_ahi || hit_ack || hit_canc);
  wire acc_err = req_valid && !(rd_ok || wr_ok);
  wire any_wr  = req_valid && req_write;
  wire do_rd   = req_valid && rd_ok;
  wire do_wr   = req_valid && wr_ok;

  wire [63:0] new_alarm = {alarm_hi_q, req_wdata};
  wire        past_due  = $signed(new_alarm) <= $signed(time_q);
  wire        reached   = $signed(time_q) >= $signed({alarm_hi_q, alarm_lo_q});
  wire        fire      = armed_q && reached && !any_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q      <= '0;
      snap_hi_q   <= '0;
      alarm_lo_q  <= '0;
      alarm_hi_q  <= '0;
      armed_q     <= 1'b0;
      irq_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      time_q      <= time_q + INC_NS;
      rsp_valid_q <= req_valid;
      rsp_err_q   <= acc_err;
      rsp_rdata_q <= '0;
      if (fire) begin
        armed_q <= 1'b0;
        irq_q   <= 1'b1;
      end
      if (do_rd) begin
        if (hit_tlo) begin
          rsp_rdata_q <= time_q[31:0];
          snap_hi_q   <= time_q[63:32];
        end else begin
          rsp_rdata_q <= snap_hi_q;
        end
      end
      if (do_wr) begin
        if (hit_alo) begin
          alarm_lo_q <= req_wdata;
          if (past_due) begin
            irq_q   <= 1'b1;
            armed_q <= 1'b0;
          end else begin
            armed_q <= 1'b1;
          end
        end
        if (hit_ahi) alarm_hi_q <= req_wdata;
        if (hit_ack) irq_q <= 1'b0;
        if (hit_canc) begin
          irq_q   <= 1'b0;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign rsp_err   = rsp_err_q;
  assign irq       = irq_q;

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> time_q == $past(time_q) + INC_NS); // R1

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write && hit_tlo) |=> $stable(snap_hi_q)); // R2

  AST_HI_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && hit_ahi) |=> $stable(armed_q) && $stable(irq_q)); // R3

  AST_PAST_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && hit_alo && past_due) |=> irq_q && !armed_q); // R4

  AST_FIRE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_q && !armed_q); // R5

  AST_ACK_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && hit_ack) |=> !irq_q && armed_q == $past(armed_q)); // R6

  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && hit_canc) |=> !irq_q && !armed_q); // R7

  AST_ERR_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && req_write) |=> $stable(irq_q) && $stable(armed_q) &&
                               $stable(alarm_lo_q) && $stable(alarm_hi_q)); // R9

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && rsp_rdata == 32'd0); // R9

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10

  AST_RSP_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(do_wr && (hit_ack || hit_canc))) |=> irq_q); // R11

  AST_WR_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && any_wr && !(do_wr && (hit_alo || hit_canc))) |=> armed_q); // R12

endmodule

// File: tb/nsec_alarm_timer_bench.sv
module nsec_alarm_timer_bench;
  localparam int      CLK_PERIOD = 10;
  localparam longint  INC_L      = 64'h0000_0000_9000_0007;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        irq;

  int     n_checks = 0;
  int     n_fail   = 0;
  bit     done     = 1'b0;
  longint ecount;

  nsec_alarm_timer #(.INC_NS(INC_L), .ADDR_W(12)) u_nsec_alarm_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, ecount);
    end
  endtask

  task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output bit er, output longint k);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    k = ecount;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    chk(rsp_valid === 1'b1, "R10", longint'(rsp_valid), 1);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; bit er; longint k;
    acc(1'b1, a, d, rd, er, k);
    chk(er == 1'b0, "R9", longint'(er), 0);
  endtask

  task automatic set_alarm(input longint a, output longint klo);
    logic [31:0] rd; bit er; longint k;
    acc(1'b1, 12'h00C, a[63:32], rd, er, k);
    acc(1'b1, 12'h008, a[31:0], rd, er, klo);
  endtask

  task automatic wait_irq(output longint seen);
    for (int i = 0; i < 40 && irq !== 1'b1; i++) @(negedge clk);
    seen = ecount;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; bit er; longint k, k2, klo, seen, a, t;
    idle(3);
    chk(irq === 1'b0, "R11 reset irq", longint'(irq), 0);
    chk(rsp_valid === 1'b0, "R10 reset rsp", longint'(rsp_valid), 0);
    rst_n = 1'b1;
    idle(2);
    chk(rsp_valid === 1'b0, "R10 idle", longint'(rsp_valid), 0);

    acc(1'b0, 12'h004, 0, rd, er, k);
    chk(rd == 32'd0 && !er, "R2 reset snapshot", longint'(rd), 0);

    for (int j = 0; j < 6; j++) begin
      acc(1'b0, 12'h000, 0, rd, er, k);
      t = INC_L * k;
      chk(rd == t[31:0] && !er, "R1 time low", longint'(rd), longint'(t[31:0]));
      idle(j);
      acc(1'b0, 12'h004, 0, rd, er, k2);
      chk(rd == t[63:32] && !er, "R2 snapshot high", longint'(rd), longint'(t[63:32]));
    end

    for (int m = -2; m <= 5; m++) begin
      for (int off = -1; off <= 1; off++) begin
        a = INC_L * (ecount + 1 + m) + off;
        set_alarm(a, klo);
        if (a <= INC_L * klo) begin
          chk(irq === 1'b1, "R4 immediate", longint'(irq), 1);
        end else begin
          chk(irq === 1'b0, "R5 not early", longint'(irq), 0);
          wait_irq(seen);
          chk(seen == (a + INC_L - 1) / INC_L + 1, "R5 fire cycle", seen, (a + INC_L - 1) / INC_L + 1);
        end
        wr(12'h014, 0);
        chk(irq === 1'b0, "R7 cancel clears", longint'(irq), 0);
      end
    end

    a = INC_L * (ecount + 1);
    set_alarm(a, klo);
    chk(irq === 1'b1, "R4 equal time", longint'(irq), 1);
    wr(12'h010, 0);
    chk(irq === 1'b0, "R6 ack clears", longint'(irq), 0);
    idle(8);
    chk(irq === 1'b0, "R4 stays unarmed", longint'(irq), 0);

    set_alarm(64'h8000_0000_FFFF_FFFF, klo);
    chk(irq === 1'b1, "R8 signed past", longint'(irq), 1);
    wr(12'h010, 0);
    idle(6);
    chk(irq === 1'b0, "R8 unarmed", longint'(irq), 0);

    a = INC_L * (ecount + 1 + 3);
    set_alarm(a, klo);
    wr(12'h010, 0);
    wait_irq(seen);
    chk(seen == klo + 4, "R6 ack keeps armed", seen, klo + 4);
    idle(10);
    chk(irq === 1'b1, "R11 level holds", longint'(irq), 1);

    wr(12'h00C, 32'h0);
    idle(3);
    chk(irq === 1'b1, "R3 hi write no irq change", longint'(irq), 1);
    wr(12'h014, 0);
    chk(irq === 1'b0, "R7", longint'(irq), 0);
    wr(12'h00C, 32'h7FFF_FFFF);
    idle(5);
    chk(irq === 1'b0, "R3 hi write no arm", longint'(irq), 0);

    a = INC_L * (ecount + 1 + 3);
    set_alarm(a, klo);
    wr(12'h014, 0);
    idle(8);
    chk(irq === 1'b0, "R7 cancel pending", longint'(irq), 0);

    a = INC_L * (ecount + 1 + 3);
    set_alarm(a, klo);
    while (ecount < klo + 6) begin
      wr(12'h00C, a[63:32]);
      chk(irq === 1'b0, "R12 deferred", longint'(irq), 0);
    end
    k = ecount;
    @(negedge clk);
    chk(irq === 1'b1 && ecount == k + 1, "R12 fires after writes", longint'(irq), 1);

    acc(1'b0, 12'h000, 0, rd, er, k);
    t = INC_L * k;
    acc(1'b1, 12'h018, 32'h1, rd, er, k2);
    chk(er && rd == 0, "R9 write unlisted", longint'(er), 1);
    acc(1'b1, 12'h011, 32'h1, rd, er, k2);
    chk(er && irq === 1'b1, "R9 misaligned ack ignored", longint'(irq), 1);
    acc(1'b1, 12'h015, 32'h1, rd, er, k2);
    chk(er && irq === 1'b1, "R9 misaligned cancel ignored", longint'(irq), 1);
    acc(1'b1, 12'h000, 32'h1, rd, er, k2);
    chk(er && rd == 0, "R9 write read-only", longint'(er), 1);
    foreach (rd[i]) begin end
    for (int i = 0; i < 6; i++) begin
      logic [11:0] bad;
      case (i)
        0: bad = 12'h008; 1: bad = 12'h00C; 2: bad = 12'h010;
        3: bad = 12'h014; 4: bad = 12'hFFC; default: bad = 12'h001;
      endcase
      acc(1'b0, bad, 0, rd, er, k2);
      chk(er && rd == 0, "R9 bad read", longint'(rd), 0);
    end
    acc(1'b0, 12'h004, 0, rd, er, k2);
    chk(!er && rd == t[63:32], "R9 snapshot untouched", longint'(rd), longint'(t[63:32]));
    chk(irq === 1'b1, "R11 still high", longint'(irq), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule